// File: doc/BRIEF.md
# Latched monitor alarm and interrupt unit

This block watches the health of a four-lane optical link and of the module around it. It takes live per-lane status inputs: receive loss of signal, transmit fault, and receive and transmit clock-recovery loss of lock. It also takes 16-bit monitor samples. Each lane reports receive power, transmit bias and transmit power. The module as a whole reports temperature and supply voltage.

Every sample is compared with four thresholds. The outcomes are held in sticky flag bits, which are arranged as a byte-addressed field spanning addresses 3 to 14. A flag clears only when its byte is read, or when the whole unit is reset. An active-low interrupt output is low while any flag is set whose mask bit is clear. An upstream serial-bus slave issues a single-cycle read strobe with a byte address. It takes the byte from `rdData` in that cycle, and the read clears that byte on the same clock edge.

Top module: `mon_flag_unit`

## Requirements
- R1: Driving `rstN` low clears every flag at once and holds `intN` high. After reset, the bytes at addresses 3, 4, 5, 7 and 9 to 14 read as 0x00.
- R2: A flag whose condition is present at a rising clock edge becomes 1 at that edge. It stays 1 after the condition goes away, until its byte is read or the unit is reset.
- R3: With `rdStb` high and `rdAddr` in the range 3 to 14, `rdData` returns the addressed byte in the same cycle, and that byte's flags clear at the next edge. The flags of every other byte are left as they were. With `rdStb` high and an address outside 3 to 14, `rdData` is 0x00 and no flag changes. Byte 8 always reads 0x00. With `rdStb` low, `rdData` is 0x00.
- R4: A read returns, for each bit, the stored flag OR its live condition. The clear takes priority over a condition present at the read edge. A condition that is still present one edge later sets the flag again.
- R5: Status byte layout, with bit n-1 for lane n. Address 3 bits 3..0 hold receive loss of signal. Address 4 bits 3..0 hold transmit fault. Address 5 bits 7..4 hold transmit loss of lock and bits 3..0 hold receive loss of lock. All other bits in these bytes read 0.
- R6: Module monitor bytes. Temperature flags sit in address 6 bits 7..4, and supply-voltage flags in address 7 bits 7..4. Within each nibble the order from the top bit down is: high alarm, low alarm, high warning, low warning.
- R7: Lane monitor bytes. Receive power uses addresses 9 and 10, transmit bias uses 11 and 12, and transmit power uses 13 and 14. The first byte of each pair holds lane 1 in bits 7..4 and lane 2 in bits 3..0. The second byte holds lane 3 and lane 4 in the same way. The nibble order is the same as in R6.
- R8: A threshold bus is 64 bits wide, from the top down: high alarm, low alarm, high warning, low warning, 16 bits each. One bus is shared by all lanes of a quantity. A high flag's condition is sample > threshold, and a low flag's condition is sample < threshold. Both comparisons are strict and unsigned.
- R9: Address 6 bit 0 sets exactly once, at the first clock edge after reset is released. It clears when byte 6 is read and does not set again until the next reset.
- R10: `intN` is low exactly while some flag is 1 and its mask bit is 0. Mask bit k*8+b belongs to bit b of address 3+k. Changing the mask alone takes effect at once and does not alter any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all flags |
| rxLos | input | 4 | Live receive loss of signal, bit n-1 = lane n |
| txFault | input | 4 | Live transmit fault, bit n-1 = lane n |
| rxLol | input | 4 | Live receive loss of lock, bit n-1 = lane n |
| txLol | input | 4 | Live transmit loss of lock, bit n-1 = lane n |
| rxPwr | input | 64 | Receive power samples, lane n at bits 16n-1..16n-16 |
| txBias | input | 64 | Transmit bias samples, same lane packing |
| txPwr | input | 64 | Transmit power samples, same lane packing |
| tempSmp | input | 16 | Module temperature sample |
| vccSmp | input | 16 | Module supply sample |
| thrRxPwr | input | 64 | Receive power thresholds (R8 packing) |
| thrTxBias | input | 64 | Transmit bias thresholds |
| thrTxPwr | input | 64 | Transmit power thresholds |
| thrTemp | input | 64 | Temperature thresholds |
| thrVcc | input | 64 | Supply thresholds |
| intMask | input | 96 | Interrupt mask, one bit per flag bit, 1 = blocked |
| rdStb | input | 1 | Single-cycle flag byte read strobe |
| rdAddr | input | 8 | Byte address of the read |
| rdData | output | 8 | Read data, valid in the strobe cycle |
| intN | output | 1 | Active-low interrupt |

## Verification
Samples are placed just past a threshold, exactly on it, and at 0xFFFF. Together these separate strict from inclusive comparisons and unsigned from signed ones, and they show which of the four nibble bits each case should set. Status lines are pulsed for a single cycle, held across a read, and raised only in the cycle of the read. This separates sticky storage from a live copy and shows the clear taking priority over a new condition. Reads of a neighbouring byte, of an out-of-range address and of the empty byte 8 show that only the addressed byte clears. Toggling the mask without any read shows that masking gates only the interrupt and leaves the flags themselves unchanged.

// File: rtl/mon_flag_pkg.sv
package mon_flag_pkg;
  localparam int SMP_W      = 16;
  localparam int NUM_CH     = 4;
  localparam int ADDR_W     = 8;
  localparam int FIRST_BYTE = 3;
  localparam int NUM_BYTES  = 12;
  localparam int FLAG_W     = NUM_BYTES * 8;
  localparam int THR_W      = 4 * SMP_W;
  localparam int CH_MONS    = 3;
  // bit offsets inside the flag vector (byte index = address - FIRST_BYTE)
  localparam int LOS_OFS    = 0;
  localparam int FAULT_OFS  = 8;
  localparam int RXLOL_OFS  = 16;
  localparam int TXLOL_OFS  = 20;
  localparam int TEMP_OFS   = 28;
  localparam int INIT_BIT   = 24;
  localparam int VCC_OFS    = 36;
  localparam int CH_MON_IDX0 = 6;
  localparam int BYTES_PER_MON = NUM_CH / 2;

  typedef struct packed {
    logic [NUM_BYTES-1:0] selByte;
    logic                 setInit;
  } flagCtl_t;
endpackage

// File: rtl/mon_flag_cmp.sv
module mon_flag_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0]   smp,
  input  logic [4*W-1:0] thr,
  output logic [3:0]     flg
);
  logic [W-1:0] hiAlm, loAlm, hiWrn, loWrn;

  assign {hiAlm, loAlm, hiWrn, loWrn} = thr;
  assign flg = {smp > hiAlm, smp < loAlm, smp > hiWrn, smp < loWrn};
endmodule

// File: rtl/mon_flag_ctrl.sv
module mon_flag_ctrl
  import mon_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output flagCtl_t          ctl
);
  logic              initSeen;
  logic              inRange;
  logic [ADDR_W-1:0] ofs;

  assign ofs     = rdAddr - ADDR_W'(FIRST_BYTE);
  assign inRange = rdStb && (rdAddr >= ADDR_W'(FIRST_BYTE)) && (ofs < ADDR_W'(NUM_BYTES));

  always_comb begin
    ctl.selByte = '0;
    if (inRange) ctl.selByte = NUM_BYTES'(1) << ofs;
    ctl.setInit = !initSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initSeen <= 1'b0;
    else       initSeen <= 1'b1;
  end
endmodule

// File: rtl/mon_flag_dp.sv
module mon_flag_dp
  import mon_flag_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  flagCtl_t                ctl,
  input  logic [NUM_CH-1:0]       rxLos,
  input  logic [NUM_CH-1:0]       txFault,
  input  logic [NUM_CH-1:0]       rxLol,
  input  logic [NUM_CH-1:0]       txLol,
  input  logic [NUM_CH*SMP_W-1:0] rxPwr,
  input  logic [NUM_CH*SMP_W-1:0] txBias,
  input  logic [NUM_CH*SMP_W-1:0] txPwr,
  input  logic [SMP_W-1:0]        tempSmp,
  input  logic [SMP_W-1:0]        vccSmp,
  input  logic [THR_W-1:0]        thrRxPwr,
  input  logic [THR_W-1:0]        thrTxBias,
  input  logic [THR_W-1:0]        thrTxPwr,
  input  logic [THR_W-1:0]        thrTemp,
  input  logic [THR_W-1:0]        thrVcc,
  input  logic [FLAG_W-1:0]       intMask,
  output logic [FLAG_W-1:0]       flagQ,
  output logic [FLAG_W-1:0]       liveVec,
  output logic [7:0]              rdData,
  output logic                    intN
);
  logic [NUM_CH*SMP_W-1:0] chSmp [CH_MONS];
  logic [THR_W-1:0]        chThr [CH_MONS];
  logic [3:0]              chFlg [CH_MONS][NUM_CH];
  logic [3:0]              tempFlg, vccFlg;
  logic [FLAG_W-1:0]       flagNext;

  assign chSmp[0] = rxPwr;
  assign chSmp[1] = txBias;
  assign chSmp[2] = txPwr;
  assign chThr[0] = thrRxPwr;
  assign chThr[1] = thrTxBias;
  assign chThr[2] = thrTxPwr;

  for (genvar m = 0; m < CH_MONS; m++) begin : g_mon
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mon_flag_cmp #(.W(SMP_W)) u_cmp (
        .smp(chSmp[m][c*SMP_W +: SMP_W]),
        .thr(chThr[m]),
        .flg(chFlg[m][c])
      );
    end
  end

  mon_flag_cmp #(.W(SMP_W)) u_cmpTemp (.smp(tempSmp), .thr(thrTemp), .flg(tempFlg));
  mon_flag_cmp #(.W(SMP_W)) u_cmpVcc  (.smp(vccSmp),  .thr(thrVcc),  .flg(vccFlg));

  // live condition vector laid out exactly like the flag field
  always_comb begin
    liveVec = '0;
    liveVec[LOS_OFS   +: NUM_CH] = rxLos;
    liveVec[FAULT_OFS +: NUM_CH] = txFault;
    liveVec[RXLOL_OFS +: NUM_CH] = rxLol;
    liveVec[TXLOL_OFS +: NUM_CH] = txLol;
    liveVec[TEMP_OFS  +: 4]      = tempFlg;
    liveVec[VCC_OFS   +: 4]      = vccFlg;
    for (int m = 0; m < CH_MONS; m++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        liveVec[(CH_MON_IDX0 + m*BYTES_PER_MON + c/2)*8 + ((c % 2 == 0) ? 4 : 0) +: 4] = chFlg[m][c];
      end
    end
  end

  // sticky update: read clear wins over new conditions, init set wins over all
  always_comb begin
    flagNext = flagQ | liveVec;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (ctl.selByte[k]) flagNext[k*8 +: 8] = 8'h00;
    end
    if (ctl.setInit) flagNext[INIT_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  always_comb begin
    rdData = 8'h00;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (ctl.selByte[k]) rdData = rdData | flagQ[k*8 +: 8] | liveVec[k*8 +: 8];
    end
  end

  assign intN = ~|(flagQ & ~intMask);
endmodule

// File: rtl/mon_flag_unit.sv
module mon_flag_unit
  import mon_flag_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       rxLos,
  input  logic [NUM_CH-1:0]       txFault,
  input  logic [NUM_CH-1:0]       rxLol,
  input  logic [NUM_CH-1:0]       txLol,
  input  logic [NUM_CH*SMP_W-1:0] rxPwr,
  input  logic [NUM_CH*SMP_W-1:0] txBias,
  input  logic [NUM_CH*SMP_W-1:0] txPwr,
  input  logic [SMP_W-1:0]        tempSmp,
  input  logic [SMP_W-1:0]        vccSmp,
  input  logic [THR_W-1:0]        thrRxPwr,
  input  logic [THR_W-1:0]        thrTxBias,
  input  logic [THR_W-1:0]        thrTxPwr,
  input  logic [THR_W-1:0]        thrTemp,
  input  logic [THR_W-1:0]        thrVcc,
  input  logic [FLAG_W-1:0]       intMask,
  input  logic                    rdStb,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [7:0]              rdData,
  output logic                    intN
);
  flagCtl_t          ctl;
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] liveVec;

  mon_flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdAddr(rdAddr), .ctl(ctl)
  );

  mon_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rxLos(rxLos), .txFault(txFault), .rxLol(rxLol), .txLol(txLol),
    .rxPwr(rxPwr), .txBias(txBias), .txPwr(txPwr),
    .tempSmp(tempSmp), .vccSmp(vccSmp),
    .thrRxPwr(thrRxPwr), .thrTxBias(thrTxBias), .thrTxPwr(thrTxPwr),
    .thrTemp(thrTemp), .thrVcc(thrVcc),
    .intMask(intMask), .flagQ(flagQ), .liveVec(liveVec),
    .rdData(rdData), .intN(intN)
  );
endmodule

// File: rtl/mon_flag_chk.sv
module mon_flag_chk
  import mon_flag_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [FLAG_W-1:0] flagQ,
  input logic [FLAG_W-1:0] liveVec,
  input logic              intN
);
  logic [FLAG_W-1:0] clrBits;
  logic [FLAG_W-1:0] noInit;
  logic [1:0]        initRise;
  logic              initPrev;

  always_comb begin
    clrBits = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (rdStb && (int'(rdAddr) == FIRST_BYTE + k)) clrBits[k*8 +: 8] = 8'hFF;
    end
    noInit = '1;
    noInit[INIT_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initRise <= 2'd0;
      initPrev <= 1'b0;
    end else begin
      initPrev <= flagQ[INIT_BIT];
      if (flagQ[INIT_BIT] && !initPrev && initRise != 2'd3) initRise <= initRise + 2'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rstN) |-> (flagQ == '0 && intN)); // R1
  AST_FLAG_HOLDS:  assert property (@(posedge clk) disable iff (!rstN)
                     (($past(flagQ) & ~$past(clrBits) & ~flagQ) == '0)); // R2
  AST_FLAG_SETS:   assert property (@(posedge clk) disable iff (!rstN)
                     (($past(liveVec) & ~$past(clrBits) & ~flagQ) == '0)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
                     (($past(clrBits) & flagQ & noInit) == '0)); // R3
  AST_INIT_ONCE:   assert property (@(posedge clk) disable iff (!rstN) initRise <= 2'd1); // R9
endmodule

bind mon_flag_unit mon_flag_chk u_chk (
  .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdAddr(rdAddr),
  .flagQ(flagQ), .liveVec(liveVec), .intN(intN)
);

// File: tb/mon_flag_unit_bench.sv
module mon_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] THR = {16'd1000, 16'd100, 16'd800, 16'd200};
  localparam logic [15:0] MID = 16'd500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] rxLos = '0, txFault = '0, rxLol = '0, txLol = '0;
  logic [63:0] rxPwr = {4{MID}}, txBias = {4{MID}}, txPwr = {4{MID}};
  logic [15:0] tempSmp = MID, vccSmp = MID;
  logic [95:0] intMask = '0;
  logic rdStb = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic intN;
  int total = 0;
  int bad = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_flag_unit u_mon_flag_unit (
    .clk(clk), .rstN(rstN), .rxLos(rxLos), .txFault(txFault), .rxLol(rxLol), .txLol(txLol),
    .rxPwr(rxPwr), .txBias(txBias), .txPwr(txPwr), .tempSmp(tempSmp), .vccSmp(vccSmp),
    .thrRxPwr(THR), .thrTxBias(THR), .thrTxPwr(THR), .thrTemp(THR), .thrVcc(THR),
    .intMask(intMask), .rdStb(rdStb), .rdAddr(rdAddr), .rdData(rdData), .intN(intN)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the read edge
  task automatic readByte(input logic [7:0] a, output logic [7:0] d);
    rdStb = 1'b1;
    rdAddr = a;
    #1 d = rdData;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic expectByte(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    readByte(a, d);
    check8(tag, d, exp);
  endtask

  task automatic t_reset_init();
    repeat (3) @(negedge clk);
    check8("R1 intN high in reset", {7'b0, intN}, 8'h01);
    rstN = 1'b1;
    @(negedge clk);
    check8("R10 init flag drives intN low", {7'b0, intN}, 8'h00);
    expectByte("R9 init flag set after reset", 8'd6, 8'h01);
    expectByte("R9 init flag cleared by read", 8'd6, 8'h00);
    check8("R10 intN high after clearing", {7'b0, intN}, 8'h01);
    repeat (3) @(negedge clk);
    expectByte("R9 init flag does not return", 8'd6, 8'h00);
  endtask

  task automatic t_sticky_los();
    rxLos = 4'b0100;
    @(negedge clk);
    rxLos = '0;
    repeat (3) @(negedge clk);
    check8("R2 sticky flag raises intN", {7'b0, intN}, 8'h00);
    rdAddr = 8'd3;
    #1 check8("R3 rdData zero without strobe", rdData, 8'h00);
    expectByte("R2 R5 lane3 rx LOS latched", 8'd3, 8'h04);
    expectByte("R3 byte cleared after read", 8'd3, 8'h00);
    check8("R10 intN released", {7'b0, intN}, 8'h01);
  endtask

  task automatic t_byte_isolation();
    txFault = 4'b0001;
    rxLol = 4'b0010;
    txLol = 4'b1000;
    @(negedge clk);
    txFault = '0; rxLol = '0; txLol = '0;
    expectByte("R5 tx fault lane1", 8'd4, 8'h01);
    expectByte("R3 R5 loss of lock byte untouched", 8'd5, 8'h82);
    expectByte("R3 fault byte stays clear", 8'd4, 8'h00);
    rxLos = 4'b0100;
    @(negedge clk);
    rxLos = '0;
    expectByte("R3 out-of-range read is zero", 8'd20, 8'h00);
    expectByte("R3 byte 8 reads zero", 8'd8, 8'h00);
    expectByte("R3 out-of-range read clears nothing", 8'd3, 8'h04);
  endtask

  task automatic t_live_read();
    rxLos = 4'b0001;
    @(negedge clk);
    expectByte("R4 held condition reads one", 8'd3, 8'h01);
    @(negedge clk);
    rxLos = '0;
    expectByte("R4 flag re-latched after read", 8'd3, 8'h01);
    rxLos = 4'b0010;
    readByte(8'd3, got);
    rxLos = '0;
    check8("R4 condition in read cycle reported", got, 8'h02);
    expectByte("R4 clear wins at read edge", 8'd3, 8'h00);
  endtask

  task automatic pulseSmp(input int sel, input int lane, input logic [15:0] v);
    case (sel)
      0: rxPwr[lane*16 +: 16] = v;
      1: txBias[lane*16 +: 16] = v;
      2: txPwr[lane*16 +: 16] = v;
      3: tempSmp = v;
      default: vccSmp = v;
    endcase
    @(negedge clk);
    rxPwr = {4{MID}}; txBias = {4{MID}}; txPwr = {4{MID}};
    tempSmp = MID; vccSmp = MID;
  endtask

  task automatic t_monitors();
    pulseSmp(0, 1, 16'd1001);
    expectByte("R7 R8 lane2 rx power above high alarm", 8'd9, 8'h0A);
    pulseSmp(0, 1, 16'd1000);
    expectByte("R8 on high alarm threshold only warning", 8'd9, 8'h02);
    pulseSmp(0, 2, 16'd99);
    expectByte("R7 R8 lane3 rx power below low alarm", 8'd10, 8'h50);
    pulseSmp(0, 2, 16'd100);
    expectByte("R8 on low alarm threshold only warning", 8'd10, 8'h10);
    pulseSmp(3, 0, 16'hFFFF);
    expectByte("R6 R8 unsigned temperature high", 8'd6, 8'hA0);
    pulseSmp(4, 0, 16'd50);
    expectByte("R6 supply low alarm and warning", 8'd7, 8'h50);
    pulseSmp(1, 3, 16'd900);
    expectByte("R7 lane4 bias high warning", 8'd12, 8'h02);
    pulseSmp(1, 3, 16'd800);
    expectByte("R8 on high warning threshold no flag", 8'd12, 8'h00);
    pulseSmp(2, 0, 16'd150);
    expectByte("R7 lane1 tx power low warning", 8'd13, 8'h10);
  endtask

  task automatic t_mask();
    intMask[7:0] = 8'hFF;
    rxLos = 4'b0001;
    @(negedge clk);
    rxLos = '0;
    @(negedge clk);
    check8("R10 masked flag keeps intN high", {7'b0, intN}, 8'h01);
    intMask = '0;
    #1 check8("R10 unmask drives intN low", {7'b0, intN}, 8'h00);
    @(negedge clk);
    expectByte("R10 masked flag still latched", 8'd3, 8'h01);
    check8("R10 intN high after read", {7'b0, intN}, 8'h01);
  endtask

  task automatic t_reset_clears();
    rxLos = 4'hF;
    rxPwr[15:0] = 16'd2000;
    @(negedge clk);
    rxLos = '0;
    rxPwr = {4{MID}};
    rstN = 1'b0;
    #1 check8("R1 reset releases intN at once", {7'b0, intN}, 8'h01);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectByte("R1 LOS byte cleared by reset", 8'd3, 8'h00);
    expectByte("R1 rx power byte cleared by reset", 8'd9, 8'h00);
    expectByte("R9 init flag again after reset", 8'd6, 8'h01);
  endtask

  initial begin
    t_reset_init();
    t_sticky_los();
    t_byte_isolation();
    t_live_read();
    t_monitors();
    t_mask();
    t_reset_clears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule